// File: doc/BRIEF.md
# LAPD Message Octet Transmitter

This block sends a stored data-link message as a LAPD frame, one octet at a time, through one byte-wide overhead slot of an outbound framed stream. The host loads the message bytes, the message length and a constant overhead byte through a small register port, then sets a start bit. The block builds the serial frame. It sends an opening flag, then the message bytes least significant bit first, then a 16-bit frame check sequence, then a closing flag. A zero is inserted after every run of five ones in the message and check sequence. The serial bits are packed into octets, and each octet is handed out on a frame-slot strobe.

The octet goes into the GC slot or the NR slot, chosen by a select input. A slot that is not carrying the link gets its fallback value: the host constant byte for GC, zero for NR. Once started, the frame is sent again after a programmable number of strobes, which stands for one second. Flag octets fill the time between frames. A busy flag shows that a frame is being built. A completion status bit is cleared by reading it and, when the enable bit is set, drives an interrupt line.

Top module: `lapd_octet_tx`

## Requirements
- R1: In the message and check-sequence bits, a 0 is inserted after every run of five consecutive 1s. This includes a run that ends on the last check-sequence bit. Flag bits are never stuffed and do not count toward a run.
- R2: The frame is sent in this order: 0x7E, the message bytes in index order, the check sequence, then 0x7E. All bits go out LSB first, and the first bit sent is bit 0 of an octet. The check sequence is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, run over the unstuffed message bits. It is sent inverted, bit 0 first. An unfilled final octet is completed with flag bits 0x7E[k..7], where k is the bit position reached. One octet is delivered per strobe, and a frame always starts on an octet boundary.
- R3: With `slot_sel`=0 the link octet appears on `gc_byte`. With `slot_sel`=1 it appears on `nr_byte`, and `nr_byte` reads 0x00 whenever it is not carrying the link.
- R4: While the start bit is 1 and `slot_sel`=0, the host GC register has no effect on `gc_byte`. In every other case `gc_byte` equals that register (address 0x02, reset 0x00).
- R5: A frame is started only by a write to the control register (address 0x00) that changes bit 0 (start) from 0 to 1. Writing 1 while it already reads 1 starts nothing.
- R6: While start is 1, a new frame is queued every `REPEAT_STROBES` strobes after the rising write. A queued frame waits for any frame in progress to finish. Between frames every octet is 0x7E. Writing start to 0 stops further repeats.
- R7: Control bit 2 (busy, read-only) is 1 from the moment the block begins building a frame until its closing flag has been packed, and 0 otherwise.
- R8: Control bit 3 (done) sets when a frame's closing flag has been packed. It clears on a read strobe of address 0x00, but a set in the same cycle wins. `irq` equals done AND control bit 1 (interrupt enable). All control bits reset to 0.
- R9: The length register (address 0x01, reset 1) accepts only values 1..`MAX_LEN`. Any other write leaves it unchanged. Message byte i is written at address 0x80+i.
- R10: Strobes must be at least 12 clock cycles apart. An octet is complete whenever a strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears done on address 0x00) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| frame_strobe | input | 1 | One pulse per outbound frame, requests an octet |
| slot_sel | input | 1 | 0: link in GC slot, 1: link in NR slot |
| gc_byte | output | 8 | GC overhead byte for the current frame |
| nr_byte | output | 8 | NR overhead byte for the current frame |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest cases to reach are a stuff bit at an octet edge and a stuff bit owed after the last check-sequence bit, just before the closing flag. A queued repeat that must wait for a frame still in progress is equally hard. The stimulus loads messages that hold flag-like bytes and long all-ones stretches, including a maximum-length message. That message takes longer than the shortened repeat period, so frames run back to back and stuffing crosses many octet edges. A bit-queue model rebuilds every frame from the rules and predicts both slot bytes on every clock.

// File: rtl/lapd_octet_tx.sv
module lapd_octet_tx #(
  parameter int MAX_LEN        = 82,
  parameter int REPEAT_STROBES = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       frame_strobe,
  input  logic       slot_sel,
  output logic [7:0] gc_byte,
  output logic [7:0] nr_byte,
  output logic       irq
);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int RW = $clog2(REPEAT_STROBES + 1);
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [15:0] POLY = 16'h8408;

  typedef enum logic [2:0] {S_IDLE, S_OPEN, S_DATA, S_FCS, S_CLOSE} gen_t;

  logic [7:0]    buf_q [MAX_LEN];
  logic [LW-1:0] msg_len;
  logic [7:0]    gc_reg;
  logic          start_q, ien_q, busy_q, done_q, pend_q;
  logic [RW-1:0] rep_cnt;
  gen_t          st;
  logic [3:0]    cnt;
  logic [LW-1:0] byte_idx;
  logic [2:0]    ones;
  logic [15:0]   crc;
  logic [7:0]    acc;
  logic [3:0]    acnt;
  logic [7:0]    link_q;

  wire ctrl_wr    = reg_we && reg_addr == 8'h00;
  wire start_rise = ctrl_wr && reg_wdata[0] && !start_q;
  wire ctrl_rd    = reg_re && reg_addr == 8'h00;
  wire take       = frame_strobe && acnt == 4'd8;
  wire gen_go     = acnt != 4'd8;
  wire buf_we     = reg_we && reg_addr[7] && (int'(reg_addr[6:0]) < MAX_LEN);
  wire len_ok     = reg_wdata != 8'd0 && int'(reg_wdata) <= MAX_LEN;

  wire [7:0] cur_byte  = buf_q[byte_idx];
  wire       data_bit  = cur_byte[cnt[2:0]];
  wire       fcs_bit   = ~crc[cnt];
  wire       stuff_zn  = st == S_DATA || st == S_FCS || (st == S_CLOSE && cnt == 4'd0);
  wire       do_stuff  = stuff_zn && ones == 3'd5;
  wire [15:0] crc_nx   = {1'b0, crc[15:1]} ^ ((crc[0] ^ data_bit) ? POLY : 16'h0000);
  wire       last_byte = byte_idx == msg_len - 1'b1;

  logic bit_out;
  always_comb begin
    bit_out = FLAG[acnt[2:0]];
    if (do_stuff)              bit_out = 1'b0;
    else if (st == S_DATA)     bit_out = data_bit;
    else if (st == S_FCS)      bit_out = fcs_bit;
    else if (st == S_OPEN || st == S_CLOSE) bit_out = FLAG[cnt[2:0]];
  end

  always_ff @(posedge clk) if (buf_we) buf_q[reg_addr[6:0]] <= reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_len <= LW'(1);
      gc_reg  <= 8'h00;
      start_q <= 1'b0;
      ien_q   <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == 8'h00) begin
        start_q <= reg_wdata[0];
        ien_q   <= reg_wdata[1];
      end
      if (reg_addr == 8'h01 && len_ok) msg_len <= reg_wdata[LW-1:0];
      if (reg_addr == 8'h02) gc_reg <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= 4'd0;
      byte_idx <= '0;
      ones     <= 3'd0;
      crc      <= 16'hFFFF;
      acc      <= FLAG;
      acnt     <= 4'd0;
      link_q   <= FLAG;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pend_q   <= 1'b0;
      rep_cnt  <= '0;
    end else begin
      if (ctrl_rd) done_q <= 1'b0;
      if (take) begin
        link_q <= acc;
        acnt   <= 4'd0;
      end
      if (gen_go) begin
        acc[acnt[2:0]] <= bit_out;
        acnt <= acnt + 4'd1;
        unique case (st)
          S_IDLE: if (pend_q && acnt == 4'd0) begin
            st       <= S_OPEN;
            cnt      <= 4'd1;
            pend_q   <= 1'b0;
            busy_q   <= 1'b1;
            crc      <= 16'hFFFF;
            byte_idx <= '0;
          end
          S_OPEN: begin
            if (cnt == 4'd7) begin
              st   <= S_DATA;
              cnt  <= 4'd0;
              ones <= 3'd0;
            end else cnt <= cnt + 4'd1;
          end
          S_DATA: begin
            if (do_stuff) ones <= 3'd0;
            else begin
              crc  <= crc_nx;
              ones <= data_bit ? ones + 3'd1 : 3'd0;
              if (cnt == 4'd7) begin
                cnt <= 4'd0;
                if (last_byte) st <= S_FCS;
                else byte_idx <= byte_idx + 1'b1;
              end else cnt <= cnt + 4'd1;
            end
          end
          S_FCS: begin
            if (do_stuff) ones <= 3'd0;
            else begin
              ones <= fcs_bit ? ones + 3'd1 : 3'd0;
              if (cnt == 4'd15) begin
                st  <= S_CLOSE;
                cnt <= 4'd0;
              end else cnt <= cnt + 4'd1;
            end
          end
          S_CLOSE: begin
            if (do_stuff) ones <= 3'd0;
            else if (cnt == 4'd7) begin
              st     <= S_IDLE;
              cnt    <= 4'd0;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else cnt <= cnt + 4'd1;
          end
          default: st <= S_IDLE;
        endcase
      end
      if (take && start_q) begin
        if (rep_cnt == RW'(REPEAT_STROBES - 1)) begin
          rep_cnt <= '0;
          pend_q  <= 1'b1;
        end else rep_cnt <= rep_cnt + 1'b1;
      end
      if (start_rise) begin
        rep_cnt <= '0;
        pend_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      8'h00:   reg_rdata = {4'b0000, done_q, busy_q, ien_q, start_q};
      8'h01:   reg_rdata = 8'(msg_len);
      8'h02:   reg_rdata = gc_reg;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign gc_byte = (start_q && !slot_sel) ? link_q : gc_reg;
  assign nr_byte = (start_q &&  slot_sel) ? link_q : 8'h00;
  assign irq     = ien_q & done_q;

  AST_STROBE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> acnt == 4'd8) else $error("strobe before octet ready"); // R10
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acnt <= 4'd8) else $error("octet count overflow"); // R10
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd5) else $error("ones run exceeds five"); // R1
  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> acnt == 4'd1) else $error("frame not octet aligned"); // R2
  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q) else $error("busy fell without done"); // R7
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_len != '0 && int'(msg_len) <= MAX_LEN) else $error("length out of range"); // R9
endmodule

// File: tb/tb_lapd_octet_tx.sv
`timescale 1ns/1ps
module tb_lapd_octet_tx;
  localparam int MAXL = 82;
  localparam int REP  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0, frame_strobe = 1'b0, slot_sel = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata, gc_byte, nr_byte;
  logic irq;

  lapd_octet_tx #(.MAX_LEN(MAXL), .REPEAT_STROBES(REP)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_strobe(frame_strobe),
    .slot_sel(slot_sel), .gc_byte(gc_byte), .nr_byte(nr_byte), .irq(irq));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0, cmp_en = 0;
  string cur_req = "R2";

  bit q[$];
  logic [7:0] m_buf [MAXL];
  int m_len = 1, m_rep = 0;
  logic [7:0] m_gc = 8'h00, m_out = 8'h7E;
  bit m_start = 0, m_ien = 0, m_pend = 0, m_done = 0, in_frame = 0, first_oct = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_flag();
    for (int i = 0; i < 8; i++) q.push_back(1'((8'h7E >> i) & 1));
  endtask

  task automatic push_stuffed(bit b, ref int ones);
    q.push_back(b);
    ones = b ? ones + 1 : 0;
    if (ones == 5) begin q.push_back(1'b0); ones = 0; end
  endtask

  task automatic build_frame();
    int ones = 0;
    logic [15:0] c = 16'hFFFF;
    push_flag();
    for (int k = 0; k < m_len; k++)
      for (int i = 0; i < 8; i++) begin
        bit b = m_buf[k][i];
        bit fb = c[0] ^ b;
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
        push_stuffed(b, ones);
      end
    for (int i = 0; i < 16; i++) push_stuffed(~c[i], ones);
    push_flag();
    while (q.size() % 8 != 0) q.push_back(1'((8'h7E >> (q.size() % 8)) & 1));
    in_frame = 1;
    first_oct = 1;
  endtask

  task automatic tick();
    bit we = reg_we, re = reg_re, stb = frame_strobe;
    logic [7:0] a = reg_addr, d = reg_wdata;
    bit frame_end = 0, check_busy = 0;
    @(posedge clk);
    #2;
    if (!cmp_en) return;
    if (re && a == 8'h00) m_done = 0;
    if (stb) begin
      if (q.size() >= 8) begin
        for (int i = 0; i < 8; i++) m_out[i] = q.pop_front();
        if (first_oct) begin check_busy = 1; first_oct = 0; end
        if (q.size() == 0) begin frame_end = 1; in_frame = 0; m_done = 1; end
      end else m_out = 8'h7E;
      if (m_start) begin
        if (m_rep == REP - 1) begin m_rep = 0; m_pend = 1; end
        else m_rep++;
      end
      if (q.size() == 0 && m_pend) begin m_pend = 0; build_frame(); end
    end
    if (we) begin
      if (a == 8'h00) begin
        if (d[0] && !m_start) begin m_pend = 1; m_rep = 0; end
        m_start = d[0];
        m_ien = d[1];
      end
      if (a == 8'h01 && d >= 1 && d <= MAXL) m_len = d;
      if (a == 8'h02) m_gc = d;
      if (a >= 8'h80 && a < 8'h80 + MAXL) m_buf[a - 8'h80] = d;
    end
    begin
      logic [7:0] eg = (m_start && !slot_sel) ? m_out : m_gc;
      logic [7:0] en = (m_start && slot_sel) ? m_out : 8'h00;
      check(gc_byte == eg, (m_start && !slot_sel) ? cur_req : "R4", gc_byte, eg);
      check(nr_byte == en, (m_start && slot_sel) ? cur_req : "R3", nr_byte, en);
    end
    if (frame_end && reg_addr == 8'h00) begin
      check(reg_rdata[2] == 1'b0, "R7 busy after frame", reg_rdata[2], 0);
      check(reg_rdata[3] == 1'b1, "R8 done after frame", reg_rdata[3], 1);
      check(irq == m_ien, "R8 irq gating", irq, m_ien);
    end
    if (check_busy && reg_addr == 8'h00)
      check(reg_rdata[2] == 1'b1, "R7 busy during frame", reg_rdata[2], 1);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0; reg_addr = 8'h00; reg_wdata = 8'h00;
  endtask

  task automatic peek(logic [7:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = 8'h00;
  endtask

  task automatic strobes(int n);
    for (int s = 0; s < n; s++) begin
      frame_strobe = 1;
      tick();
      frame_strobe = 0;
      repeat (11) tick();
    end
  endtask

  initial begin
    #(10ns * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < MAXL; i++) m_buf[i] = 8'h00;
    repeat (3) tick();
    rst_n = 1;
    cmp_en = 1;
    repeat (12) tick();
    peek(8'h00, v); check(v == 8'h00, "R8 reset ctrl", v, 0);
    peek(8'h01, v); check(v == 8'h01, "R9 reset length", v, 1);
    check(gc_byte == 8'h00 && nr_byte == 8'h00, "R4 reset slots", {gc_byte, nr_byte}, 0);
    check(irq == 1'b0, "R8 reset irq", irq, 0);

    wr(8'h01, 8'h00); peek(8'h01, v); check(v == 8'h01, "R9 zero length ignored", v, 1);
    wr(8'h01, MAXL + 1); peek(8'h01, v); check(v == 8'h01, "R9 oversize ignored", v, 1);
    wr(8'h01, MAXL); peek(8'h01, v); check(v == MAXL, "R9 max accepted", v, MAXL);

    wr(8'h02, 8'hA5);
    strobes(3);

    wr(8'h80, 8'h01); wr(8'h81, 8'h7E); wr(8'h82, 8'hFF); wr(8'h01, 8'h03);
    cur_req = "R2";
    wr(8'h00, 8'h03);
    strobes(25);
    peek(8'h00, v); check(v[3] == m_done, "R8 done readback", v[3], m_done);
    reg_re = 1; reg_addr = 8'h00; tick(); reg_re = 0;
    check(irq == 1'b0, "R8 cleared by read", irq, 0);

    cur_req = "R5";
    wr(8'h00, 8'h03);
    strobes(30);
    cur_req = "R6";
    strobes(20);

    slot_sel = 1; cur_req = "R3";
    strobes(30);

    slot_sel = 0; cur_req = "R8";
    wr(8'h00, 8'h01);
    strobes(25);

    cur_req = "R4";
    wr(8'h00, 8'h00);
    strobes(30);

    for (int i = 0; i < MAXL; i++) wr(8'h80 + 8'(i), (i % 3 == 0) ? 8'hF8 : 8'hFF);
    wr(8'h01, MAXL);
    cur_req = "R1";
    wr(8'h00, 8'h03);
    strobes(140);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule